// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block sits between a device core that raises single-cycle event strobes and the one interrupt pin seen by a host processor. Each event strobe latches into its own status bit, and that bit stays set until software clears it by writing a 1 to it. One status bit carries a live bus-suspend level rather than a latched event, and one bit position is reserved. The status bits are masked per bit by an enable register and as a group by a global enable. Their OR is the combined request.

The combined request drives the `irq_out` pin in one of two signalling modes. In level mode the pin is active for as long as the request stands. In pulse mode the pin is active for a fixed number of clock cycles, and only when the request rises from 0 to 1. Software chooses the active level of the pin. Out of reset the pin is active low, level mode is selected, and nothing is enabled.

All registers are reached through a small synchronous port. A write takes effect at the clock edge that samples it. A read loads `rd_data` at the edge that samples `rd_en`.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A 1 on an event bit of `evt_strobe` (bits 8 and 5..0) at a clock edge sets the matching status bit at that edge. The bit stays set until it is cleared.
- R2: A write to address 0 clears every event status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 are left unchanged.
- R3: If a strobe and a clear reach the same status bit at the same edge, the bit ends up set.
- R4: Status bit 7 always reads the current `bus_suspend` input, and strobes and writes have no effect on it. Status bit 6 always reads 0, whatever the strobes or writes.
- R5: Address 1 is the enable register, bits 8..0. Bit 6 always reads back 0. A status bit adds to the combined request only while its enable bit is 1.
- R6: Address 2, bit 0 is the global enable. While it is 0, `irq_out` stays at its inactive level whatever is pending.
- R7: Address 3 holds the pin configuration. Bit 0 is polarity (1 = active high, 0 = active low). Bit 1 is mode (0 = level, 1 = pulse). After a synchronous reset every register reads 0 and `irq_out` is 1 (inactive).
- R8: In level mode `irq_out` is active exactly while the combined request is 1. It follows the request one clock edge after the edge that changed the request, so a strobe shows on the pin at the second edge.
- R9: In pulse mode a 0-to-1 rise of the combined request makes `irq_out` active for exactly PULSE_CYC cycles. The pulse starts with the same delay as in level mode. New events arriving while the request stays 1 give no further pulse; the next pulse needs the request to fall to 0 and rise again.
- R10: When `rd_en` is 1 at an edge, `rd_data` loads the addressed register with all unused bits 0. At other edges `rd_data` holds its value. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_strobe | input | 9 | One-cycle event strobes, one per status bit |
| bus_suspend | input | 1 | Live bus-suspend level, shown as status bit 7 |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 global enable, 3 pin configuration |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Interrupt pin, registered |

## Verification
The bench targets a strobe and a write-1 clear that land on the same bit at the same edge; a design that gives the clear priority would lose that event for good. It fires new events while a pulse-mode request is already high, which catches a design that pulses once per event or stretches the pulse past PULSE_CYC. It also writes to the reserved and live positions and reads them back, which exposes a bit 6 that latches strobes or a bit 7 that can be cleared. Further checks cover a pin one cycle early or late against the level-mode delay, and a pin that asserts while the global enable is off.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Status layout: bit 7 mirrors a live level, bit 6 is held at zero.
  localparam int N_STAT   = 9;
  localparam int LIVE_BIT = 7;
  localparam int RSVD_BIT = 6;
  localparam int ADDR_W   = 2;

  // Bits that latch strobes.
  localparam logic [N_STAT-1:0] EVT_MASK =
    ~((N_STAT'(1) << LIVE_BIT) | (N_STAT'(1) << RSVD_BIT));

  // Bits that software may enable.
  localparam logic [N_STAT-1:0] ENAB_MASK = ~(N_STAT'(1) << RSVD_BIT);

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_MODE = 2'd2,
    SEL_CONF = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_irq_pkg::*;
#(
  parameter int NB = N_STAT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] evt_set,
  input  logic [NB-1:0] evt_clr,
  input  logic          live_in,
  output logic [NB-1:0] view
);

  for (genvar g = 0; g < NB; g++) begin : g_bit
    if (g == LIVE_BIT) begin : g_live
      logic unused_live;
      assign unused_live = evt_set[g] ^ evt_clr[g];
      assign view[g] = live_in;
    end else if (g == RSVD_BIT) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = evt_set[g] ^ evt_clr[g];
      assign view[g] = 1'b0;
    end else begin : g_evt
      logic held;
      // A set at the same edge as a clear wins.
      always_ff @(posedge clk) begin
        if (rst) held <= 1'b0;
        else     held <= (held & ~evt_clr[g]) | evt_set[g];
      end
      assign view[g] = held;
    end
  end

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NB     = N_STAT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [NB-1:0]     stat_view,
  output logic [DATA_W-1:0] rd_data,
  output logic [NB-1:0]     clr_vec,
  output logic [NB-1:0]     enab_q,
  output logic              glb_en_q,
  output logic              pol_q,
  output logic              pulse_q
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_next;
  logic              unused_hi;

  assign sel       = reg_sel_e'(addr);
  assign unused_hi = ^wr_data[DATA_W-1:NB];
  assign clr_vec   = (wr_en && sel == SEL_STAT) ? wr_data[NB-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enab_q   <= '0;
      glb_en_q <= 1'b0;
      pol_q    <= 1'b0;
      pulse_q  <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_ENAB: enab_q   <= wr_data[NB-1:0] & ENAB_MASK;
        SEL_MODE: glb_en_q <= wr_data[0];
        SEL_CONF: begin
          pol_q   <= wr_data[0];
          pulse_q <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_STAT: rd_next[NB-1:0] = stat_view;
      SEL_ENAB: rd_next[NB-1:0] = enab_q;
      SEL_MODE: rd_next[0]      = glb_en_q;
      SEL_CONF: rd_next[1:0]    = {pulse_q, pol_q};
      default:  rd_next         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper #(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pend_any,
  input  logic pol_hi,
  input  logic pulse_mode,
  output logic irq_out
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             pend_q;
  logic             rise;
  logic             act;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  assign rise  = pend_any & ~pend_q;
  assign cnt_n = rise ? CNT_W'(PULSE_CYC)
               : ((cnt_q != '0) ? cnt_q - CNT_W'(1) : '0);
  assign act   = pulse_mode ? (cnt_n != '0) : pend_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      irq_out <= 1'b1;
    end else begin
      pend_q  <= pend_any;
      cnt_q   <= cnt_n;
      irq_out <= pol_hi ? act : ~act;
    end
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_STAT-1:0] evt_strobe,
  input  logic              bus_suspend,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);

  logic [N_STAT-1:0] stat_view;
  logic [N_STAT-1:0] clr_vec;
  logic [N_STAT-1:0] enab_q;
  logic              glb_en_q;
  logic              pol_q;
  logic              pulse_q;
  logic              pend_any;

  evt_status_bank #(.NB(N_STAT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_strobe),
    .evt_clr (clr_vec),
    .live_in (bus_suspend),
    .view    (stat_view)
  );

  evt_reg_port #(.DATA_W(DATA_W), .NB(N_STAT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .stat_view (stat_view),
    .rd_data   (rd_data),
    .clr_vec   (clr_vec),
    .enab_q    (enab_q),
    .glb_en_q  (glb_en_q),
    .pol_q     (pol_q),
    .pulse_q   (pulse_q)
  );

  assign pend_any = glb_en_q & (|(stat_view & enab_q));

  irq_pin_shaper #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk        (clk),
    .rst        (rst),
    .pend_any   (pend_any),
    .pol_hi     (pol_q),
    .pulse_mode (pulse_q),
    .irq_out    (irq_out)
  );

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [N_STAT-1:0] evt_strobe,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_out,
  input logic [N_STAT-1:0] stat_view,
  input logic [N_STAT-1:0] enab_q,
  input logic              glb_en_q,
  input logic              pol_q,
  input logic              pulse_q
);

  localparam int HI_W = $clog2(PULSE_CYC + 1);

  logic            req;
  logic [HI_W-1:0] hi_len;

  assign req = glb_en_q & (|(stat_view & enab_q));

  always_ff @(posedge clk) begin
    if (rst || !req)                  hi_len <= '0;
    else if (hi_len < HI_W'(PULSE_CYC)) hi_len <= hi_len + HI_W'(1);
  end

  // R1 R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(evt_strobe & EVT_MASK)) |=>
      ((stat_view & $past(evt_strobe & EVT_MASK)) == $past(evt_strobe & EVT_MASK)));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_STAT && ((evt_strobe & wr_data[N_STAT-1:0]) == '0)) |=>
      ((stat_view & $past(wr_data[N_STAT-1:0] & EVT_MASK)) == '0));

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[RSVD_BIT] == 1'b0);

  // R6
  mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!glb_en_q && !pulse_q) |=> (irq_out == !$past(pol_q)));

  // R8
  level_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse_q && glb_en_q && (|(stat_view & enab_q))) |=> (irq_out == $past(pol_q)));

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && hi_len == HI_W'(PULSE_CYC)) |=> (irq_out == !$past(pol_q)));

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_strobe (evt_strobe),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .irq_out    (irq_out),
  .stat_view  (stat_view),
  .enab_q     (enab_q),
  .glb_en_q   (glb_en_q),
  .pol_q      (pol_q),
  .pulse_q    (pulse_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;

  localparam int P = 8;
  localparam logic [8:0] EVM = 9'h13F;
  localparam logic [8:0] ENM = 9'h1BF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  evt = '0;
  logic        bus_susp = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  always #4 clk = ~clk;

  evt_irq_ctrl #(.PULSE_CYC(P), .DATA_W(16)) i_evt_irq_ctrl (
    .clk         (clk),
    .rst         (rst),
    .evt_strobe  (evt),
    .bus_suspend (bus_susp),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .irq_out     (irq_out)
  );

  // Reference state, built from the requirements.
  logic [8:0]  m_stat = '0, m_en = '0;
  logic        m_gen = 0, m_pol = 0, m_pulse = 0, m_anyq = 0, m_irq = 1;
  int          m_cnt = 0;
  logic [15:0] m_rd = '0;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_tick();
    logic [8:0] view, clr;
    logic any, rise, actv;
    int cn;
    view = (m_stat & EVM) | {1'b0, bus_susp, 7'b0};
    any  = m_gen & (|(view & m_en));
    if (rd_en) begin
      case (addr)
        2'd0: m_rd = {7'b0, view};
        2'd1: m_rd = {7'b0, m_en};
        2'd2: m_rd = {15'b0, m_gen};
        default: m_rd = {14'b0, m_pulse, m_pol};
      endcase
    end
    rise  = any & ~m_anyq;
    cn    = rise ? P : ((m_cnt > 0) ? m_cnt - 1 : 0);
    actv  = m_pulse ? (cn != 0) : any;
    m_irq = m_pol ? actv : ~actv;
    m_anyq = any;
    m_cnt  = cn;
    clr    = (wr_en && addr == 2'd0) ? wr_data[8:0] : 9'h0;
    m_stat = ((m_stat & ~clr) | evt) & EVM;
    if (wr_en) begin
      case (addr)
        2'd1: m_en = wr_data[8:0] & ENM;
        2'd2: m_gen = wr_data[0];
        2'd3: begin m_pol = wr_data[0]; m_pulse = wr_data[1]; end
        default: ;
      endcase
    end
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic cyc(input logic [8:0] e, input logic we, input logic [1:0] a,
                     input logic [15:0] wd, input logic re);
    string itag;
    evt = e; wr_en = we; addr = a; wr_data = wd; rd_en = re;
    @(posedge clk);
    itag = m_pulse ? "R9" : "R8";
    model_tick();
    @(negedge clk);
    evt = '0; wr_en = 1'b0; rd_en = 1'b0;
    check(itag, {15'b0, irq_out}, {15'b0, m_irq}, "irq_out vs model");
    check("R10", rd_data, m_rd, "rd_data vs model");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(9'h0, 1'b0, 2'd0, 16'h0, 1'b0);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    cyc(9'h0, 1'b0, a, 16'h0, 1'b1);
    v = rd_data;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    cyc(9'h0, 1'b1, a, d, 1'b0);
  endtask

  task automatic count_active(input int n, input logic [8:0] mid_evt, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      cyc((i == 3) ? mid_evt : 9'h0, 1'b0, 2'd0, 16'h0, 1'b0);
      if (irq_out === 1'b1) hits++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int hits;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: reset state
    check("R7", {15'b0, irq_out}, 16'h1, "irq_out after reset");
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check("R7", v, 16'h0, "register after reset");
    end

    // R1: strobe latches and holds
    cyc(9'h008, 1'b0, 2'd0, 16'h0, 1'b0);
    idle(3);
    rd_reg(2'd0, v);
    check("R1", v, 16'h0008, "status holds strobe");

    // R2: write-1 clear only touches ones
    cyc(9'h021, 1'b0, 2'd0, 16'h0, 1'b0);
    wr_reg(2'd0, 16'h0009);
    rd_reg(2'd0, v);
    check("R2", v, 16'h0020, "selective clear");

    // R3: set beats clear
    cyc(9'h001, 1'b1, 2'd0, 16'h0001, 1'b0);
    rd_reg(2'd0, v);
    check("R3", v, 16'h0021, "set wins over clear");

    // R4: live and reserved bits
    bus_susp = 1'b1;
    cyc(9'h0C0, 1'b1, 2'd0, 16'hFFFF, 1'b0);
    rd_reg(2'd0, v);
    check("R4", v, 16'h0080, "live bit 7, reserved bit 6");
    bus_susp = 1'b0;
    rd_reg(2'd0, v);
    check("R4", v, 16'h0000, "live bit follows input");
    bus_susp = 1'b1;

    // R5: enable register read-back
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, v);
    check("R5", v, 16'h01BF, "enable bit 6 reads zero");

    // R6: global enable off masks a pending, enabled bit
    idle(2);
    check("R6", {15'b0, irq_out}, 16'h1, "masked while global off");
    wr_reg(2'd2, 16'h0001);
    idle(1);
    check("R8", {15'b0, irq_out}, 16'h0, "level active low once enabled");

    // R7: polarity flip
    wr_reg(2'd3, 16'h0001);
    idle(1);
    check("R7", {15'b0, irq_out}, 16'h1, "active high after polarity write");

    // R8: level latency
    bus_susp = 1'b0;
    wr_reg(2'd0, 16'h01FF);
    idle(1);
    check("R8", {15'b0, irq_out}, 16'h0, "inactive with nothing pending");
    cyc(9'h010, 1'b0, 2'd0, 16'h0, 1'b0);
    check("R8", {15'b0, irq_out}, 16'h0, "not yet at first edge");
    idle(1);
    check("R8", {15'b0, irq_out}, 16'h1, "active at second edge");

    // R5: disabled source does not request
    wr_reg(2'd1, 16'h0000);
    idle(1);
    check("R5", {15'b0, irq_out}, 16'h0, "disabled bit gives no request");
    wr_reg(2'd1, 16'h01FF);

    // R9: pulse mode, one pulse per rise
    wr_reg(2'd0, 16'h01FF);
    wr_reg(2'd3, 16'h0003);
    idle(2);
    cyc(9'h001, 1'b0, 2'd0, 16'h0, 1'b0);
    count_active(3 * P, 9'h004, hits);
    check("R9", 16'(hits), 16'(P), "pulse width, no retrigger while high");
    wr_reg(2'd0, 16'h01FF);
    idle(2);
    cyc(9'h020, 1'b0, 2'd0, 16'h0, 1'b0);
    count_active(3 * P, 9'h000, hits);
    check("R9", 16'(hits), 16'(P), "second pulse after fall and rise");

    // Random phase against the reference state
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) bus_susp = ~bus_susp;
      cyc(9'($urandom & $urandom & $urandom),
          (($urandom % 4) == 0),
          2'($urandom % 4),
          16'($urandom),
          (($urandom % 2) == 0));
    end

    finish_run();
  end

endmodule